// File: doc/BRIEF.md
# Write-Protection Register with One-Time Lock

This block keeps the write-protection state of a 256-word by 16-bit serial EEPROM and decides whether a requested program operation may go ahead. The state has four parts: an 8-bit boundary register, a flag that marks the register as cleared, a latch that must be set before the register may be changed, and a lock bit that, once set, freezes the register and flag for good. Words whose address is numerically above the boundary are protected unless the cleared flag is set.

The command controller sends each decoded protection instruction through an instruction strobe, with its opcode, address and the level of the protection-enable pin. It asks the block, through a combinational query port, whether a single write, a page write of up to four words or a write-all may be executed. The register and flag are always visible on a 9-bit readout bus, which the serial shifter sends out register first and flag last. A soft reset models loss of the volatile latch only. The asynchronous power-on reset models a fresh part and loads parameterized initial values.

Top module: `prot_reg_unit`

## Requirements
- R1: After power-on reset the boundary register equals INIT_REG, the cleared flag equals INIT_FLAG, the lock equals INIT_LOCK and the enable latch is clear. rd_bits_o carries the boundary in bits [8:1] and the cleared flag in bit 0.
- R2: A query of kind 2'b00 (single word) is allowed exactly when the cleared flag is 1 or qry_addr_i is less than or equal to the boundary.
- R3: A query of kind 2'b01 (page) checks word k at address {qry_addr_i[7:2], qry_addr_i[1:0]+k}, wrapping in the low two bits, for k from 0 to qry_count_i-1. A count of 0 checks only the start word and a count above 4 checks all four. The query is allowed only if every checked word would pass the R2 test.
- R4: A query of kind 2'b10 (write-all) is allowed exactly when the cleared flag is 1. Kind 2'b11 is always refused.
- R5: An instruction acts only when instr_valid_i and instr_pre_i are both high. Opcode 2'b10 (register read) changes no state.
- R6: Opcode 2'b01 (register write) loads the boundary from instr_addr_i and sets the cleared flag to 0.
- R7: Opcode 2'b11 with address 8'hFF (register clear) sets the boundary to 8'hFF and the cleared flag to 1. Opcode 2'b11 with any other address has no effect.
- R8: Opcode 2'b00 with address bits [7:6] = 2'b11 sets the enable latch when wp_en_i is high. Register write, clear and disable take effect only if the latch was already set and wp_en_i is high.
- R9: Opcode 2'b00 with address 8'h00 (disable) sets the lock bit. Once the lock is set, it stays set and the boundary and flag never change again until power-on reset.
- R10: soft_rst_i clears the enable latch and leaves the boundary, flag and lock unchanged.
- R11: Power-on reset restores the R1 state even after the lock has been set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| soft_rst_i | input | 1 | Synchronous reset of the volatile enable latch |
| instr_valid_i | input | 1 | Instruction strobe, one cycle per decoded instruction |
| instr_pre_i | input | 1 | Level of the protection-enable pin during the instruction |
| instr_op_i | input | 2 | Two-bit instruction opcode |
| instr_addr_i | input | 8 | Address field of the instruction |
| wp_en_i | input | 1 | Level of the write-enable pin |
| qry_kind_i | input | 2 | Query kind: 00 single, 01 page, 10 write-all, 11 reserved |
| qry_addr_i | input | 8 | Start word address of the queried write |
| qry_count_i | input | 3 | Word count of a page query |
| qry_allow_o | output | 1 | High when the queried write may proceed |
| rd_bits_o | output | 9 | Boundary register (bits 8:1) and cleared flag (bit 0) |

## Verification
The assertions check on every cycle that the lock never falls and freezes the readout, that the readout holds when no strobe with PRE high arrives or when the enable latch is clear, that soft reset drops the latch, and that single and write-all answers never grant access that the boundary or flag forbids. Only the bench's scenarios can show the page-query wrap of the low address bits, the exact values loaded by write and clear, that the two-bit address tags select enable and disable, and that power-on reset clears a lock the soft reset kept.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [1:0] {
    OP_SPECIAL = 2'b00,
    OP_PWRITE  = 2'b01,
    OP_PREAD   = 2'b10,
    OP_PCLEAR  = 2'b11
  } prot_op_e;

  typedef enum logic [1:0] {
    Q_SINGLE = 2'b00,
    Q_PAGE   = 2'b01,
    Q_ALL    = 2'b10,
    Q_RSVD   = 2'b11
  } qry_kind_e;

  typedef struct packed {
    logic en;
    logic wr;
    logic clr;
    logic dis;
  } prot_cmd_t;
endpackage

// File: rtl/prot_decode.sv
module prot_decode
  import prot_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          valid_i,
  input  logic          pre_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  output prot_cmd_t     cmd_o
);
  always_comb begin
    cmd_o = '0;
    if (valid_i && pre_i) begin
      unique case (prot_op_e'(op_i))
        OP_SPECIAL: begin
          if (addr_i[AW-1 -: 2] == 2'b11) cmd_o.en = 1'b1;
          else if (addr_i == '0)          cmd_o.dis = 1'b1;
        end
        OP_PWRITE: cmd_o.wr = 1'b1;
        OP_PCLEAR: cmd_o.clr = &addr_i;
        default: ;  // read: readout bus is always live
      endcase
    end
  end
endmodule

// File: rtl/prot_state.sv
module prot_state
  import prot_pkg::*;
#(
  parameter int            AW        = 8,
  parameter logic [AW-1:0] INIT_REG  = '1,
  parameter logic          INIT_FLAG = 1'b1,
  parameter logic          INIT_LOCK = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  prot_cmd_t     cmd_i,
  input  logic          wp_en_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] bound_o,
  output logic          flag_o,
  output logic          lock_o,
  output logic          pr_en_o
);
  logic          pr_en_q, lock_q, flag_q;
  logic [AW-1:0] bound_q;
  logic          auth;

  assign auth = pr_en_q && wp_en_i && !lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pr_en_q <= 1'b0;
      lock_q  <= INIT_LOCK;
      flag_q  <= INIT_FLAG;
      bound_q <= INIT_REG;
    end else begin
      if (soft_rst_i)                pr_en_q <= 1'b0;
      else if (cmd_i.en && wp_en_i)  pr_en_q <= 1'b1;
      if (auth) begin
        if (cmd_i.wr) begin
          bound_q <= addr_i;
          flag_q  <= 1'b0;
        end
        if (cmd_i.clr) begin
          bound_q <= '1;
          flag_q  <= 1'b1;
        end
        if (cmd_i.dis) lock_q <= 1'b1;
      end
    end
  end

  assign bound_o = bound_q;
  assign flag_o  = flag_q;
  assign lock_o  = lock_q;
  assign pr_en_o = pr_en_q;
endmodule

// File: rtl/prot_guard.sv
module prot_guard
  import prot_pkg::*;
#(
  parameter int AW         = 8,
  parameter int PAGE_WORDS = 4,
  parameter int CNT_W      = 3
) (
  input  logic [1:0]       kind_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [AW-1:0]    bound_i,
  input  logic             flag_i,
  output logic             allow_o
);
  localparam int PW = $clog2(PAGE_WORDS);

  logic [PAGE_WORDS-1:0] word_ok;

  for (genvar k = 0; k < PAGE_WORDS; k++) begin : g_word
    logic [PW-1:0] lo;
    logic [AW-1:0] waddr;
    logic          active;
    assign lo     = addr_i[PW-1:0] + PW'(k);
    assign waddr  = {addr_i[AW-1:PW], lo};
    assign active = (k == 0) || (CNT_W'(k) < count_i);
    assign word_ok[k] = !active || flag_i || (waddr <= bound_i);
  end

  always_comb begin
    unique case (qry_kind_e'(kind_i))
      Q_SINGLE: allow_o = flag_i || (addr_i <= bound_i);
      Q_PAGE:   allow_o = &word_ok;
      Q_ALL:    allow_o = flag_i;
      default:  allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/prot_reg_unit.sv
module prot_reg_unit
  import prot_pkg::*;
#(
  parameter int                AW         = 8,
  parameter int                PAGE_WORDS = 4,
  parameter int                CNT_W      = $clog2(PAGE_WORDS + 1),
  parameter logic [AW-1:0]     INIT_REG   = '1,
  parameter logic              INIT_FLAG  = 1'b1,
  parameter logic              INIT_LOCK  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             instr_valid_i,
  input  logic             instr_pre_i,
  input  logic [1:0]       instr_op_i,
  input  logic [AW-1:0]    instr_addr_i,
  input  logic             wp_en_i,
  input  logic [1:0]       qry_kind_i,
  input  logic [AW-1:0]    qry_addr_i,
  input  logic [CNT_W-1:0] qry_count_i,
  output logic             qry_allow_o,
  output logic [AW:0]      rd_bits_o
);
  prot_cmd_t     cmd;
  logic [AW-1:0] bound;
  logic          flag, locked, pr_en;

  prot_decode #(.AW(AW)) u_decode (
    .valid_i (instr_valid_i),
    .pre_i   (instr_pre_i),
    .op_i    (instr_op_i),
    .addr_i  (instr_addr_i),
    .cmd_o   (cmd)
  );

  prot_state #(
    .AW(AW), .INIT_REG(INIT_REG), .INIT_FLAG(INIT_FLAG), .INIT_LOCK(INIT_LOCK)
  ) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .cmd_i      (cmd),
    .wp_en_i    (wp_en_i),
    .addr_i     (instr_addr_i),
    .bound_o    (bound),
    .flag_o     (flag),
    .lock_o     (locked),
    .pr_en_o    (pr_en)
  );

  prot_guard #(.AW(AW), .PAGE_WORDS(PAGE_WORDS), .CNT_W(CNT_W)) u_guard (
    .kind_i  (qry_kind_i),
    .addr_i  (qry_addr_i),
    .count_i (qry_count_i),
    .bound_i (bound),
    .flag_i  (flag),
    .allow_o (qry_allow_o)
  );

  assign rd_bits_o = {bound, flag};
endmodule

// File: rtl/prot_reg_unit_chk.sv
module prot_reg_unit_chk #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          soft_rst_i,
  input logic          instr_valid_i,
  input logic          instr_pre_i,
  input logic [1:0]    qry_kind_i,
  input logic [AW-1:0] qry_addr_i,
  input logic          qry_allow_o,
  input logic [AW:0]   rd_bits_o,
  input logic          locked,
  input logic          pr_en
);
  // R9
  a_r9_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> locked);
  a_r9_lock_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> $stable(rd_bits_o));
  // R5
  a_r5_no_strobe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!instr_valid_i || !instr_pre_i) |=> $stable(rd_bits_o));
  // R8
  a_r8_latch_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pr_en |=> $stable(rd_bits_o));
  // R10
  a_r10_soft_drops_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !pr_en);
  // R2
  a_r2_single_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qry_kind_i == 2'b00 && !rd_bits_o[0] && qry_addr_i > rd_bits_o[AW:1]) |-> !qry_allow_o);
  // R4
  a_r4_wrall_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qry_kind_i == 2'b10) |-> (qry_allow_o == rd_bits_o[0]));
endmodule

bind prot_reg_unit prot_reg_unit_chk #(.AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .soft_rst_i    (soft_rst_i),
  .instr_valid_i (instr_valid_i),
  .instr_pre_i   (instr_pre_i),
  .qry_kind_i    (qry_kind_i),
  .qry_addr_i    (qry_addr_i),
  .qry_allow_o   (qry_allow_o),
  .rd_bits_o     (rd_bits_o),
  .locked        (locked),
  .pr_en         (pr_en)
);

// File: tb/sim_prot_reg_unit.sv
`timescale 1ns/1ps
module sim_prot_reg_unit;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst = 1'b0;
  logic       iv = 1'b0, ipre = 1'b0, wp = 1'b0;
  logic [1:0] iop = '0;
  logic [7:0] iaddr = '0;
  logic [1:0] qkind = 2'b11;
  logic [7:0] qaddr = '0;
  logic [2:0] qcnt = '0;
  logic       allow;
  logic [8:0] rd;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit         exp_isq[$];
  logic [8:0] exp_val[$];
  string      exp_tag[$];

  always #10 clk = ~clk;

  prot_reg_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst),
    .instr_valid_i(iv), .instr_pre_i(ipre), .instr_op_i(iop), .instr_addr_i(iaddr),
    .wp_en_i(wp), .qry_kind_i(qkind), .qry_addr_i(qaddr), .qry_count_i(qcnt),
    .qry_allow_o(allow), .rd_bits_o(rd)
  );

  // monitor: pops one expectation per falling edge
  always @(negedge clk) begin
    if (exp_val.size() > 0) begin
      bit         isq;
      logic [8:0] ev, got;
      string      tg;
      isq = exp_isq.pop_front();
      ev  = exp_val.pop_front();
      tg  = exp_tag.pop_front();
      got = isq ? {8'h0, allow} : rd;
      n_chk++;
      if (got !== ev) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", tg, got, ev);
      end
    end
  end

  function automatic logic [8:0] pk(input logic [7:0] b, input logic f);
    return {b, f};
  endfunction

  task automatic instr(input logic [1:0] op, input logic [7:0] a, input logic pre, input logic w);
    @(posedge clk); #2;
    iv = 1'b1; iop = op; iaddr = a; ipre = pre; wp = w;
    @(posedge clk); #2;
    iv = 1'b0; ipre = 1'b0; wp = 1'b0;
  endtask

  task automatic soft_reset();
    @(posedge clk); #2 soft_rst = 1'b1;
    @(posedge clk); #2 soft_rst = 1'b0;
  endtask

  task automatic exp_rd(input logic [8:0] v, input string tg);
    exp_isq.push_back(1'b0); exp_val.push_back(v); exp_tag.push_back(tg);
    @(negedge clk); #1;
  endtask

  task automatic query(input logic [1:0] k, input logic [7:0] a, input logic [2:0] c,
                       input logic e, input string tg);
    qkind = k; qaddr = a; qcnt = c;
    exp_isq.push_back(1'b1); exp_val.push_back({8'h0, e}); exp_tag.push_back(tg);
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_ni = 1'b1;
    exp_rd(pk(8'hFF, 1'b1), "R1 reset state");
    query(2'b10, 8'h00, 3'd1, 1'b1, "R4 write-all after reset");

    // R8: write without latch, enable with W low
    instr(2'b01, 8'h40, 1'b1, 1'b1);
    exp_rd(pk(8'hFF, 1'b1), "R8 write without latch ignored");
    instr(2'b00, 8'hC0, 1'b1, 1'b0);
    instr(2'b01, 8'h40, 1'b1, 1'b1);
    exp_rd(pk(8'hFF, 1'b1), "R8 enable with W low ignored");
    instr(2'b00, 8'hC5, 1'b1, 1'b1);
    instr(2'b01, 8'h43, 1'b1, 1'b0);
    exp_rd(pk(8'hFF, 1'b1), "R8 write with W low ignored");
    instr(2'b01, 8'h43, 1'b1, 1'b1);
    exp_rd(pk(8'h43, 1'b0), "R6 register write");

    // queries against boundary 0x43
    query(2'b00, 8'h43, 3'd1, 1'b1, "R2 single at boundary");
    query(2'b00, 8'h44, 3'd1, 1'b0, "R2 single above boundary");
    query(2'b00, 8'h00, 3'd1, 1'b1, "R2 single at zero");
    query(2'b01, 8'h42, 3'd4, 1'b1, "R3 page wraps low bits");
    query(2'b01, 8'h41, 3'd3, 1'b1, "R3 page three words");
    query(2'b01, 8'h3F, 3'd4, 1'b1, "R3 page below boundary");
    query(2'b01, 8'h47, 3'd2, 1'b0, "R3 page above boundary");
    query(2'b01, 8'h44, 3'd0, 1'b0, "R3 count zero checks start");
    query(2'b01, 8'h40, 3'd7, 1'b1, "R3 count above four");
    query(2'b10, 8'h00, 3'd1, 1'b0, "R4 write-all denied");
    query(2'b11, 8'h00, 3'd1, 1'b0, "R4 reserved kind denied");

    // R5
    instr(2'b01, 8'h10, 1'b0, 1'b1);
    exp_rd(pk(8'h43, 1'b0), "R5 PRE low ignored");
    instr(2'b10, 8'h00, 1'b1, 1'b1);
    exp_rd(pk(8'h43, 1'b0), "R5 read changes nothing");

    // R7
    instr(2'b11, 8'h7F, 1'b1, 1'b1);
    exp_rd(pk(8'h43, 1'b0), "R7 clear with wrong address ignored");
    instr(2'b11, 8'hFF, 1'b1, 1'b1);
    exp_rd(pk(8'hFF, 1'b1), "R7 clear");
    query(2'b10, 8'h00, 3'd1, 1'b1, "R4 write-all after clear");

    // R10
    instr(2'b01, 8'h20, 1'b1, 1'b1);
    exp_rd(pk(8'h20, 1'b0), "R6 second write");
    soft_reset();
    exp_rd(pk(8'h20, 1'b0), "R10 soft reset keeps register");
    instr(2'b01, 8'h30, 1'b1, 1'b1);
    exp_rd(pk(8'h20, 1'b0), "R10 soft reset drops latch");

    // R9
    instr(2'b00, 8'hC0, 1'b1, 1'b1);
    instr(2'b00, 8'h00, 1'b1, 1'b1);
    instr(2'b11, 8'hFF, 1'b1, 1'b1);
    exp_rd(pk(8'h20, 1'b0), "R9 clear after lock ignored");
    instr(2'b01, 8'h05, 1'b1, 1'b1);
    exp_rd(pk(8'h20, 1'b0), "R9 write after lock ignored");
    soft_reset();
    instr(2'b00, 8'hC0, 1'b1, 1'b1);
    instr(2'b01, 8'h05, 1'b1, 1'b1);
    exp_rd(pk(8'h20, 1'b0), "R9 lock survives soft reset");

    // R11
    @(posedge clk); #5 rst_ni = 1'b0;
    #25 rst_ni = 1'b1;
    exp_rd(pk(8'hFF, 1'b1), "R11 power-on reset restores state");
    instr(2'b00, 8'hC0, 1'b1, 1'b1);
    instr(2'b01, 8'h33, 1'b1, 1'b1);
    exp_rd(pk(8'h33, 1'b0), "R11 lock cleared by power-on reset");

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule